// File: doc/BRIEF.md
# Redundant-Range Successive-Approximation Controller

This block sequences a 6-bit successive-approximation conversion whose search is deliberately non-binary. The controller tracks the remaining input interval as a lower bound and a width, both in fixed point with six fractional bits below the output LSB. On every cycle it presents the midpoint of that interval to a resistor-ladder DAC and takes one decision from a differential comparator. After the decision the interval shrinks to nine sixteenths of its old width instead of one half. The extra sixteenth is an overlap margin that sits on the side from which the DAC level approached. An RC-limited ladder that settles only partially then still leaves the input inside the new interval, so the ladder needs only a short settling time on each cycle. The cost is seven comparisons for six bits.

For the two outcomes of the next decision, both candidate intervals and both candidate DAC levels are computed from registered state while the comparator is still resolving. The decision then only selects one of two prepared values. The comparator reports on two lines that are both low while it is undecided. When exactly one line is high, the next level is taken. A cycle with no valid decision holds all state and latches an error flag. A start pulse in the idle state begins a conversion. The result and a one-cycle done pulse follow the seventh decision.

Top module: `sar_ovr_ctrl`

## Requirements
- R1: After reset, dac_level, result, done and err are all 0 and the controller is idle.
- R2: A start seen while idle makes dac_level equal half of full scale (2048 with the default 12-bit level code) in the next cycle, and that first step counts as rising.
- R3: Each accepted decision sets the new width to floor(9*W/16). A low decision (cmp_lo=1) keeps the lower bound. The next dac_level is the new lower bound plus floor(new width / 2).
- R4: On a high decision (cmp_hi=1) after a rising step, the new lower bound is the current level minus floor(W/16). After a falling step it is the current level itself. A step is rising when the new level exceeds the previous level.
- R5: A decision is accepted only when exactly one of cmp_hi and cmp_lo is 1. In any other converting cycle all state, dac_level included, is held and err is set. Once set, err stays at 1 until reset.
- R6: A conversion takes exactly 7 accepted decisions. done is high for exactly one cycle, in the cycle after the seventh decision. result changes only in that cycle and then holds.
- R7: result equals floor((final lower bound + final width/2) / 64), saturated to 63. This value is within 1 LSB of floor(vin/64) when the DAC error on each step stays smaller than the margin on the settling side.
- R8: A start asserted while a conversion is in progress or finishing has no effect. No second conversion follows the done pulse.

The controller moves between its three states as follows:

| From | Condition | To |
|------|-----------|-----|
| ST_IDLE | start | ST_CONV |
| ST_CONV | accepted decision, fewer than 7 so far | ST_CONV |
| ST_CONV | no valid decision | ST_CONV, hold |
| ST_CONV | seventh accepted decision | ST_FINISH |
| ST_FINISH | always | ST_IDLE |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion; used only while idle |
| cmp_hi | input | 1 | Comparator says input is above the DAC level |
| cmp_lo | input | 1 | Comparator says input is below the DAC level |
| dac_level | output | 12 | Ladder tap code, 64 steps per output LSB, saturated at 4095 |
| result | output | 6 | Converted code, valid from the done pulse on |
| done | output | 1 | One-cycle conversion-complete pulse |
| err | output | 1 | Sticky flag for a converting cycle without a valid decision |

## Verification
The bench builds the controller with its default parameters: six result bits, six fractional bits, seven steps, a shrink factor of 9/16 and a margin of W/16. With these values every input position of the 4096-step fixed-point scale can be swept, first with an ideally settled DAC and then with a settling error of 7/64 of each step placed on the approach side. This shows that the ±1 LSB bound holds across the whole scale, the saturated top end included. Short hand-computed traces pin down the exact level sequence after rising and falling steps. Separate runs insert undecided and double-high comparator cycles and raise start while the controller is busy.

// File: rtl/sar_ovr_pkg.sv
package sar_ovr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CONV   = 2'd1,
        ST_FINISH = 2'd2
    } sar_state_e;

    localparam int BRANCH_LO = 0;
    localparam int BRANCH_HI = 1;
    localparam int N_BRANCH  = 2;

endpackage

// File: rtl/sar_ovr_fsm.sv
module sar_ovr_fsm
    import sar_ovr_pkg::*;
#(
    parameter int STEPS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic decide_ok,
    output logic load,
    output logic take,
    output logic last,
    output logic stall,
    output logic busy,
    output logic idle,
    output logic done
);

    localparam int CW = $clog2(STEPS + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(STEPS - 1);

    sar_state_e state_q;
    sar_state_e state_d;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // decision counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_CONV;
                end
            end
            ST_CONV: begin
                if (decide_ok && (cnt_q == LAST_IDX)) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        load  = 1'b0;
        take  = 1'b0;
        stall = 1'b0;
        busy  = 1'b0;
        idle  = 1'b0;
        done  = 1'b0;
        last  = (cnt_q == LAST_IDX);
        unique case (state_q)
            ST_IDLE: begin
                idle = 1'b1;
                load = start;
            end
            ST_CONV: begin
                busy  = 1'b1;
                take  = decide_ok;
                stall = !decide_ok;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: begin
                idle = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sar_ovr_lookahead.sv
module sar_ovr_lookahead
    import sar_ovr_pkg::*;
#(
    parameter int PW         = 14,
    parameter int SHRINK_NUM = 9,
    parameter int SHRINK_SH  = 4,
    parameter int MARGIN_SH  = 4
) (
    input  logic                         [PW-1:0] lo_q,
    input  logic                         [PW-1:0] w_q,
    input  logic                         [PW-1:0] lvl_q,
    input  logic                                  dir_up_q,
    output logic                         [PW-1:0] w_next,
    output logic [N_BRANCH-1:0]          [PW-1:0] lo_cand,
    output logic [N_BRANCH-1:0]          [PW-1:0] lvl_cand
);

    localparam int XW = PW + 5;

    logic [XW-1:0] prod;
    logic [PW-1:0] margin;
    logic [PW-1:0] half_next;

    always_comb begin
        prod      = XW'(w_q) * XW'(SHRINK_NUM);
        w_next    = PW'(prod >> SHRINK_SH);
        margin    = w_q >> MARGIN_SH;
        half_next = w_next >> 1;
    end

    for (genvar b = 0; b < N_BRANCH; b++) begin : g_branch
        if (b == BRANCH_HI) begin : g_hi
            // overlap margin below the level only when it was approached from below
            assign lo_cand[b] = dir_up_q ? (lvl_q - margin) : lvl_q;
        end else begin : g_lo
            assign lo_cand[b] = lo_q;
        end
        assign lvl_cand[b] = lo_cand[b] + half_next;
    end

endmodule

// File: rtl/sar_ovr_encode.sv
module sar_ovr_encode #(
    parameter int PW        = 14,
    parameter int RES_BITS  = 6,
    parameter int FRAC_BITS = 6
) (
    input  logic [PW-1:0]                   lvl,
    output logic [RES_BITS-1:0]             code,
    output logic [RES_BITS+FRAC_BITS-1:0]   tap
);

    localparam int ACC = RES_BITS + FRAC_BITS;
    localparam logic [PW-1:0] TAP_MAX  = PW'((1 << ACC) - 1);
    localparam logic [PW-1:0] CODE_MAX = PW'((1 << RES_BITS) - 1);

    logic [PW-1:0] whole;

    always_comb begin
        whole = lvl >> FRAC_BITS;
        if (whole > CODE_MAX) begin
            code = '1;
        end else begin
            code = whole[RES_BITS-1:0];
        end
        if (lvl > TAP_MAX) begin
            tap = '1;
        end else begin
            tap = lvl[ACC-1:0];
        end
    end

endmodule

// File: rtl/sar_ovr_ctrl.sv
module sar_ovr_ctrl
    import sar_ovr_pkg::*;
#(
    parameter int RES_BITS   = 6,
    parameter int FRAC_BITS  = 6,
    parameter int STEPS      = 7,
    parameter int SHRINK_NUM = 9,
    parameter int SHRINK_SH  = 4,
    parameter int MARGIN_SH  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          cmp_hi,
    input  logic                          cmp_lo,
    output logic [RES_BITS+FRAC_BITS-1:0] dac_level,
    output logic [RES_BITS-1:0]           result,
    output logic                          done,
    output logic                          err
);

    localparam int ACC = RES_BITS + FRAC_BITS;
    localparam int PW  = ACC + 2;
    localparam logic [PW-1:0] FULL_W   = PW'(1 << ACC);
    localparam logic [PW-1:0] MID_LVL  = PW'(1 << (ACC - 1));

    logic decide_ok;
    logic sel;
    logic load, take, last, stall, busy_w, idle_w;

    logic [PW-1:0] lo_q, w_q, lvl_q;
    logic          dir_up;
    logic [PW-1:0] w_next;
    logic [N_BRANCH-1:0][PW-1:0] lo_cand;
    logic [N_BRANCH-1:0][PW-1:0] lvl_cand;
    logic [N_BRANCH-1:0][RES_BITS-1:0] code_cand;
    logic [N_BRANCH-1:0][ACC-1:0]      tap_cand_unused;
    logic [RES_BITS-1:0] code_now_unused;

    assign decide_ok = cmp_hi ^ cmp_lo;
    assign sel       = cmp_hi;

    sar_ovr_fsm #(
        .STEPS(STEPS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .decide_ok(decide_ok),
        .load     (load),
        .take     (take),
        .last     (last),
        .stall    (stall),
        .busy     (busy_w),
        .idle     (idle_w),
        .done     (done)
    );

    sar_ovr_lookahead #(
        .PW        (PW),
        .SHRINK_NUM(SHRINK_NUM),
        .SHRINK_SH (SHRINK_SH),
        .MARGIN_SH (MARGIN_SH)
    ) u_look (
        .lo_q    (lo_q),
        .w_q     (w_q),
        .lvl_q   (lvl_q),
        .dir_up_q(dir_up),
        .w_next  (w_next),
        .lo_cand (lo_cand),
        .lvl_cand(lvl_cand)
    );

    // result codes for both outcomes are prepared ahead of the decision
    for (genvar b = 0; b < N_BRANCH; b++) begin : g_code
        sar_ovr_encode #(
            .PW       (PW),
            .RES_BITS (RES_BITS),
            .FRAC_BITS(FRAC_BITS)
        ) u_enc (
            .lvl (lvl_cand[b]),
            .code(code_cand[b]),
            .tap (tap_cand_unused[b])
        );
    end

    sar_ovr_encode #(
        .PW       (PW),
        .RES_BITS (RES_BITS),
        .FRAC_BITS(FRAC_BITS)
    ) u_tap (
        .lvl (lvl_q),
        .code(code_now_unused),
        .tap (dac_level)
    );

    // search-range registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            w_q    <= '0;
            lvl_q  <= '0;
            dir_up <= 1'b1;
        end else if (load) begin
            lo_q   <= '0;
            w_q    <= FULL_W;
            lvl_q  <= MID_LVL;
            dir_up <= 1'b1;
        end else if (take) begin
            lo_q   <= lo_cand[sel];
            w_q    <= w_next;
            lvl_q  <= lvl_cand[sel];
            dir_up <= sel;
        end
    end

    // result and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            err    <= 1'b0;
        end else begin
            if (take && last) begin
                result <= code_cand[sel];
            end
            if (stall) begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sar_ovr_ctrl_chk.sv
module sar_ovr_ctrl_chk #(
    parameter int ACC = 12,
    parameter int PW  = 14,
    parameter int RES = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           cmp_hi,
    input logic           cmp_lo,
    input logic [ACC-1:0] dac_level,
    input logic [RES-1:0] result,
    input logic           done,
    input logic           err,
    input logic           busy,
    input logic           idle,
    input logic           take,
    input logic [PW-1:0]  lvl_q,
    input logic           dir_up
);

    localparam logic [ACC-1:0] HALF = ACC'(1 << (ACC - 1));

    AST_START_LOADS_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start) |=> (dac_level == HALF)); // R2

    AST_DIR_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (dir_up == (lvl_q > $past(lvl_q)))); // R4

    AST_HOLD_NO_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cmp_hi == cmp_lo)) |=> $stable(lvl_q)); // R5

    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cmp_hi == cmp_lo)) |=> err); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done); // R6

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done)); // R8

endmodule

bind sar_ovr_ctrl sar_ovr_ctrl_chk #(
    .ACC(ACC),
    .PW (PW),
    .RES(RES_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmp_hi   (cmp_hi),
    .cmp_lo   (cmp_lo),
    .dac_level(dac_level),
    .result   (result),
    .done     (done),
    .err      (err),
    .busy     (busy_w),
    .idle     (idle_w),
    .take     (take),
    .lvl_q    (lvl_q),
    .dir_up   (dir_up)
);

// File: tb/sar_ovr_ctrl_bench.sv
`timescale 1ns/1ps
module sar_ovr_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmp_hi = 1'b0;
    logic        cmp_lo = 1'b0;
    logic [11:0] dac_level;
    logic [5:0]  result;
    logic        done;
    logic        err;

    int n_total = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sar_ovr_ctrl u_sar_ovr_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmp_hi   (cmp_hi),
        .cmp_lo   (cmp_lo),
        .dac_level(dac_level),
        .result   (result),
        .done     (done),
        .err      (err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        start  = 1'b0;
        cmp_hi = 1'b0;
        cmp_lo = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic kick();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic step(input bit hi, input int expv, input string req);
        cmp_hi = hi;
        cmp_lo = !hi;
        @(negedge clk);
        cmp_hi = 1'b0;
        cmp_lo = 1'b0;
        chk(dac_level == expv, req, dac_level, expv);
    endtask

    // one conversion against an ideal comparator, with settling error k/64 of each step
    task automatic run_conv(input int vin, input int k, input bit do_stall, input bit do_busy);
        int prev, lvl, e, a, ndec, cyc, ideal, diff;
        kick();
        prev = 0;
        ndec = 0;
        cyc  = 0;
        while (!done && cyc < 40) begin
            lvl = dac_level;
            if (do_stall && ndec == 3) begin
                cmp_hi = 1'b0;
                cmp_lo = 1'b0;
                @(negedge clk);
                chk(dac_level == lvl, "R5 hold on no decision", dac_level, lvl);
                chk(err == 1'b1, "R5 err set", err, 1);
                cmp_hi = 1'b1;
                cmp_lo = 1'b1;
                @(negedge clk);
                chk(dac_level == lvl, "R5 hold on double decision", dac_level, lvl);
                cyc += 2;
            end
            e = (((lvl > prev) ? (lvl - prev) : (prev - lvl)) * k) >> 6;
            a = (lvl > prev) ? (lvl - e) : (lvl + e);
            cmp_hi = (vin > a);
            cmp_lo = !(vin > a);
            start  = do_busy && (ndec == 2);
            prev = lvl;
            @(negedge clk);
            start = 1'b0;
            ndec++;
            cyc++;
        end
        cmp_hi = 1'b0;
        cmp_lo = 1'b0;
        chk(done == 1'b1, "R6 done after decisions", done, 1);
        chk(ndec == 7, "R6 decision count", ndec, 7);
        ideal = vin >> 6;
        diff  = int'(result) - ideal;
        chk(diff >= -1 && diff <= 1, "R7 result within 1 LSB", result, ideal);
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", done, 0);
        if (do_busy) begin
            lvl = dac_level;
            cmp_hi = 1'b1;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                chk(done == 1'b0 && dac_level == lvl, "R8 no restart after busy start",
                    dac_level, lvl);
            end
            cmp_hi = 1'b0;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !finished) begin
                finished = 1'b1;
                n_total++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
                $display("%0d/%0d checks passed", n_total - n_fail, n_total);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(dac_level == 0, "R1 dac_level reset", dac_level, 0);
        chk(result == 0, "R1 result reset", result, 0);
        chk(done == 0, "R1 done reset", done, 0);
        chk(err == 0, "R1 err reset", err, 0);

        // trace A: low then high after a falling step
        kick();
        chk(dac_level == 2048, "R2 first level", dac_level, 2048);
        step(1'b0, 1152, "R3 low keeps lower bound");
        step(1'b1, 1800, "R4 high after falling step");
        do_reset();

        // trace B: high after rising steps, then low
        kick();
        step(1'b1, 2944, "R4 high after first rising step");
        step(1'b1, 3448, "R4 high after rising step");
        step(1'b0, 3164, "R3 low after rising step");
        do_reset();

        // R7 sweeps: ideal settling, then settling error on approach side
        for (int v = 0; v < 4096; v += 2) run_conv(v, 0, 1'b0, 1'b0);
        for (int v = 1; v < 4096; v += 3) run_conv(v, 7, 1'b0, 1'b0);
        run_conv(4095, 7, 1'b0, 1'b0);
        chk(err == 0, "R5 no err with clean decisions", err, 0);

        // R8 start while busy
        run_conv(1000, 7, 1'b0, 1'b1);

        // R5 stalled decisions
        run_conv(2500, 0, 1'b1, 1'b0);
        run_conv(300, 0, 1'b0, 1'b0);
        chk(err == 1, "R5 err sticky", err, 1);
        do_reset();
        chk(err == 0, "R5 err cleared by reset", err, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule